// File: doc/BRIEF.md
# Privileged Control Register Unit

This unit keeps the small set of registers that only supervisor code may touch: a source function code register, a destination function code register (each three bits, one bit per function code line), the user stack pointer and a 32-bit vector base. The core reaches any of them through one register-move port. Every transfer on this port is 32 bits wide. The port is gated by the supervisor bit. A read returns its value one cycle after the request.

The unit also serves two other clients at the same time. For an alternate-address-space data access, it supplies the function code. The source register is used when memory is read, and the destination register is used when memory is written. For exception handling, it turns an 8-bit exception number into a relocated vector address: the vector base plus four times the number. This address path is combinational, so the exception sequencer can use it in the same cycle.

Top module: `priv_ctl_unit`

## Requirements
- R1: After reset, all four registers are zero, `creg_rdata_o` is zero, both flag outputs are low, and `vec_addr_o` equals four times `exc_num_i`.
- R2: A write to either function code register keeps only bits [2:0] of the write data. A read of either returns those bits with bits [31:3] zero.
- R3: Select codes are 0 for the source function code, 1 for the destination function code, 2 for the user stack pointer and 3 for the vector base. The user stack pointer and vector base store and return all 32 bits. Read data appears on `creg_rdata_o` in the cycle after the read request and is held until the next read request.
- R4: A request made while `supervisor_i` is low changes no register. A read request made this way returns zero.
- R5: A request made while `supervisor_i` is low raises `priv_viol_o` for exactly the following cycle. `illegal_reg_o` is never high at the same time.
- R6: A supervisor request with a select code from 4 to 7 raises `illegal_reg_o` for the following cycle. Such a write changes no register, and such a read returns zero.
- R7: `vec_addr_o` equals the vector base plus 4 times `exc_num_i`, modulo 2^32, in the same cycle as `exc_num_i`.
- R8: A vector base write does not change `vec_addr_o` in the cycle of the request. The new base appears in the following cycle.
- R9: `alt_fc_o` equals the source function code register when `alt_is_write_i` is 0 (memory is the source). It equals the destination function code register when `alt_is_write_i` is 1.
- R10: Exception number 32 gives address 0x80 with a base of zero and 0x4080 with a base of 0x4000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supervisor_i | input | 1 | Core is in supervisor state |
| creg_req_i | input | 1 | Register-move request this cycle |
| creg_we_i | input | 1 | 1 = write, 0 = read |
| creg_sel_i | input | 3 | Register select code |
| creg_wdata_i | input | 32 | Write data |
| creg_rdata_o | output | 32 | Read data, registered |
| priv_viol_o | output | 1 | One-cycle privilege violation pulse |
| illegal_reg_o | output | 1 | One-cycle unknown-select pulse |
| alt_is_write_i | input | 1 | Alternate-space access writes memory |
| alt_fc_o | output | 3 | Function code for the alternate-space access |
| exc_num_i | input | 8 | Exception number |
| vec_addr_o | output | 32 | Relocated vector fetch address |

## Verification
Two overlaps matter here. A vector base write can land in the same cycle that the sequencer samples `vec_addr_o`. A function code write can land in the same cycle that an alternate-space access reads `alt_fc_o`. Directed steps place a base write under a steady exception number. They require the old relocated address before the edge and the new one after it. A long random phase then mixes register moves, privilege levels, select codes, access directions and exception numbers freely. A behavioural model compares every output on every cycle, and so judges each collision against the rule that a write becomes visible one cycle later.

// File: rtl/priv_ctl_pkg.sv
package priv_ctl_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_CREG = 4;

  typedef enum logic [SEL_W-1:0] {
    CREG_SFC = 3'd0,
    CREG_DFC = 3'd1,
    CREG_USP = 3'd2,
    CREG_VBR = 3'd3
  } creg_sel_e;
endpackage

// File: rtl/pcu_rst_sync.sv
module pcu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcu_access_ctl.sv
module pcu_access_ctl
  import priv_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FC_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                sup_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [FC_W-1:0]     sfc_i,
  input  logic [FC_W-1:0]     dfc_i,
  input  logic [DATA_W-1:0]   usp_i,
  input  logic [DATA_W-1:0]   vbr_i,
  output logic [NUM_CREG-1:0] wr_en_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                priv_viol_o,
  output logic                illegal_o
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_CREG - 1);

  logic              legal;
  logic              granted;
  logic [DATA_W-1:0] rd_val;
  logic              rd_en;
  logic [DATA_W-1:0] rdata_d;
  logic              viol_d;
  logic              ill_d;

  assign legal     = (sel_i <= LAST_SEL);
  assign granted   = req_i && sup_i;
  assign wr_data_o = wdata_i;

  for (genvar g = 0; g < NUM_CREG; g++) begin : g_wr_en
    assign wr_en_o[g] = granted && we_i && (sel_i == SEL_W'(g));
  end

  always_comb begin
    rd_val = '0;
    unique case (sel_i)
      CREG_SFC: rd_val = {{(DATA_W-FC_W){1'b0}}, sfc_i};
      CREG_DFC: rd_val = {{(DATA_W-FC_W){1'b0}}, dfc_i};
      CREG_USP: rd_val = usp_i;
      CREG_VBR: rd_val = vbr_i;
      default:  rd_val = '0;
    endcase
  end

  always_comb begin
    viol_d  = req_i && !sup_i;
    ill_d   = granted && !legal;
    rd_en   = req_i && !we_i;
    rdata_d = (granted && legal) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_viol_o <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      priv_viol_o <= viol_d;
      illegal_o   <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_o <= '0;
    else if (rd_en) rdata_o <= rdata_d;
  end

  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol_o |-> $past(req_i && !sup_i)); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(priv_viol_o && illegal_o)); // R5
  AST_ILLEGAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_o && !$past(we_i)) |-> (rdata_o == '0)); // R6
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $past(req_i && sup_i)); // R6
endmodule

// File: rtl/pcu_regfile.sv
module pcu_regfile
  import priv_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FC_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CREG-1:0] wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [FC_W-1:0]     sfc_o,
  output logic [FC_W-1:0]     dfc_o,
  output logic [DATA_W-1:0]   usp_o,
  output logic [DATA_W-1:0]   vbr_o
);
  localparam int unsigned NUM_FC = 2;

  logic [FC_W-1:0]   fc_q [NUM_FC];
  logic [DATA_W-1:0] wide_q [NUM_CREG-NUM_FC];

  for (genvar g = 0; g < NUM_FC; g++) begin : g_fc
    logic [FC_W-1:0] fc_d;
    always_comb fc_d = wr_data_i[FC_W-1:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          fc_q[g] <= '0;
      else if (wr_en_i[g]) fc_q[g] <= fc_d;
    end
  end

  for (genvar g = 0; g < NUM_CREG - NUM_FC; g++) begin : g_wide
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 wide_q[g] <= '0;
      else if (wr_en_i[g+NUM_FC]) wide_q[g] <= wr_data_i;
    end
  end

  assign sfc_o = fc_q[CREG_SFC];
  assign dfc_o = fc_q[CREG_DFC];
  assign usp_o = wide_q[int'(CREG_USP) - NUM_FC];
  assign vbr_o = wide_q[int'(CREG_VBR) - NUM_FC];

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_i)); // R3
endmodule

// File: rtl/pcu_vector_gen.sv
module pcu_vector_gen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EXC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] vbr_i,
  input  logic [EXC_W-1:0]  exc_num_i,
  output logic [DATA_W-1:0] vec_addr_o
);
  localparam int unsigned OFS_W = EXC_W + 2;

  logic [OFS_W-1:0] offset;

  assign offset     = {exc_num_i, 2'b00};
  assign vec_addr_o = vbr_i + DATA_W'(offset);

  AST_VEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(vbr_i) && (exc_num_i != '0) && (exc_num_i == EXC_W'($past(exc_num_i) + 1'b1)))
      |-> (vec_addr_o == $past(vec_addr_o) + DATA_W'(4))); // R7
endmodule

// File: rtl/priv_ctl_unit.sv
module priv_ctl_unit
  import priv_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FC_W   = 3,
  parameter int unsigned EXC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supervisor_i,
  input  logic              creg_req_i,
  input  logic              creg_we_i,
  input  logic [SEL_W-1:0]  creg_sel_i,
  input  logic [DATA_W-1:0] creg_wdata_i,
  output logic [DATA_W-1:0] creg_rdata_o,
  output logic              priv_viol_o,
  output logic              illegal_reg_o,
  input  logic              alt_is_write_i,
  output logic [FC_W-1:0]   alt_fc_o,
  input  logic [EXC_W-1:0]  exc_num_i,
  output logic [DATA_W-1:0] vec_addr_o
);
  logic                rst_sync_n;
  logic [NUM_CREG-1:0] wr_en;
  logic [DATA_W-1:0]   wr_data;
  logic [FC_W-1:0]     sfc_q;
  logic [FC_W-1:0]     dfc_q;
  logic [DATA_W-1:0]   usp_q;
  logic [DATA_W-1:0]   vbr_q;

  pcu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcu_access_ctl #(.DATA_W(DATA_W), .FC_W(FC_W)) u_access (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_i       (creg_req_i),
    .we_i        (creg_we_i),
    .sup_i       (supervisor_i),
    .sel_i       (creg_sel_i),
    .wdata_i     (creg_wdata_i),
    .sfc_i       (sfc_q),
    .dfc_i       (dfc_q),
    .usp_i       (usp_q),
    .vbr_i       (vbr_q),
    .wr_en_o     (wr_en),
    .wr_data_o   (wr_data),
    .rdata_o     (creg_rdata_o),
    .priv_viol_o (priv_viol_o),
    .illegal_o   (illegal_reg_o)
  );

  pcu_regfile #(.DATA_W(DATA_W), .FC_W(FC_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .sfc_o     (sfc_q),
    .dfc_o     (dfc_q),
    .usp_o     (usp_q),
    .vbr_o     (vbr_q)
  );

  pcu_vector_gen #(.DATA_W(DATA_W), .EXC_W(EXC_W)) u_vec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .vbr_i      (vbr_q),
    .exc_num_i  (exc_num_i),
    .vec_addr_o (vec_addr_o)
  );

  always_comb begin
    alt_fc_o = alt_is_write_i ? dfc_q : sfc_q;
  end

  AST_USER_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (creg_req_i && !supervisor_i) |=> $stable({sfc_q, dfc_q, usp_q, vbr_q})); // R4
  AST_FC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(creg_req_i && supervisor_i && !creg_we_i &&
          (creg_sel_i == CREG_SFC || creg_sel_i == CREG_DFC))
      |-> (creg_rdata_o[DATA_W-1:FC_W] == '0)); // R2
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (creg_req_i && creg_sel_i > CREG_VBR) |=> $stable({sfc_q, dfc_q, usp_q, vbr_q})); // R6
endmodule

// File: tb/priv_ctl_unit_bench.sv
module priv_ctl_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        supervisor_i = 1'b0;
  logic        creg_req_i = 1'b0;
  logic        creg_we_i = 1'b0;
  logic [2:0]  creg_sel_i = '0;
  logic [31:0] creg_wdata_i = '0;
  logic [31:0] creg_rdata_o;
  logic        priv_viol_o;
  logic        illegal_reg_o;
  logic        alt_is_write_i = 1'b0;
  logic [2:0]  alt_fc_o;
  logic [7:0]  exc_num_i = '0;
  logic [31:0] vec_addr_o;

  int checks = 0;
  int failures = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  priv_ctl_unit u_priv_ctl_unit (.*);

  // Behavioural reference model
  logic [31:0] m_reg [4];
  logic [31:0] m_rdata;
  bit          m_viol, m_ill;
  int          rst_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) rst_cnt = 0;
    if (rst_cnt < 2) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_rdata = 0; m_viol = 0; m_ill = 0;
      rst_cnt++;
    end else begin
      m_viol = creg_req_i && !supervisor_i;
      m_ill  = creg_req_i && supervisor_i && (creg_sel_i > 3);
      if (creg_req_i && !creg_we_i)
        m_rdata = (supervisor_i && creg_sel_i <= 3) ? m_reg[creg_sel_i] : 0;
      if (creg_req_i && creg_we_i && supervisor_i && creg_sel_i <= 3)
        m_reg[creg_sel_i] = (creg_sel_i < 2) ? (creg_wdata_i & 32'h7) : creg_wdata_i;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(creg_rdata_o === m_rdata, "R3 rdata", creg_rdata_o, m_rdata);
      chk(priv_viol_o === m_viol, "R5 priv_viol", 32'(priv_viol_o), 32'(m_viol));
      chk(illegal_reg_o === m_ill, "R6 illegal", 32'(illegal_reg_o), 32'(m_ill));
      chk(vec_addr_o === m_reg[3] + 32'(exc_num_i) * 4, "R7 vec_addr", vec_addr_o,
          m_reg[3] + 32'(exc_num_i) * 4);
      chk(32'(alt_fc_o) === (alt_is_write_i ? m_reg[1] : m_reg[0]), "R9 alt_fc",
          32'(alt_fc_o), alt_is_write_i ? m_reg[1] : m_reg[0]);
    end
  end

  task automatic op(input bit we, input bit sup, input logic [2:0] sel, input logic [31:0] d);
    @(posedge clk); #2;
    creg_req_i = 1'b1; creg_we_i = we; supervisor_i = sup;
    creg_sel_i = sel; creg_wdata_i = d;
  endtask

  task automatic idle();
    @(posedge clk); #2;
    creg_req_i = 1'b0;
  endtask

  // read result sampled at the negedge after the request edge
  task automatic rd(input bit sup, input logic [2:0] sel);
    op(1'b0, sup, sel, '0);
    idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2 exc_num_i = 8'd5;
    @(negedge clk);
    chk(creg_rdata_o === 0 && !priv_viol_o && !illegal_reg_o, "R1 outputs", creg_rdata_o, 0);
    chk(vec_addr_o === 32'd20, "R1 vec", vec_addr_o, 32'd20);
    chk(alt_fc_o === 3'd0, "R1 alt_fc", 32'(alt_fc_o), 0);
    chk_on = 1'b1;

    // R10 base zero
    exc_num_i = 8'd32;
    @(negedge clk);
    chk(vec_addr_o === 32'h80, "R10 base0", vec_addr_o, 32'h80);

    // R2 narrow registers
    op(1'b1, 1'b1, 3'd0, 32'hFFFF_FFFD);
    op(1'b1, 1'b1, 3'd1, 32'h1234_5672);
    rd(1'b1, 3'd0);
    chk(creg_rdata_o === 32'd5, "R2 sfc", creg_rdata_o, 32'd5);
    rd(1'b1, 3'd1);
    chk(creg_rdata_o === 32'd2, "R2 dfc", creg_rdata_o, 32'd2);

    // R9 direction select
    alt_is_write_i = 1'b0; #1;
    chk(alt_fc_o === 3'd5, "R9 source", 32'(alt_fc_o), 5);
    alt_is_write_i = 1'b1; #1;
    chk(alt_fc_o === 3'd2, "R9 dest", 32'(alt_fc_o), 2);

    // R3 wide registers
    op(1'b1, 1'b1, 3'd2, 32'hDEAD_BEEF);
    rd(1'b1, 3'd2);
    chk(creg_rdata_o === 32'hDEAD_BEEF, "R3 usp", creg_rdata_o, 32'hDEAD_BEEF);

    // R8 base write timing, R10 relocated trap vector
    op(1'b1, 1'b1, 3'd3, 32'h0000_4000);
    @(negedge clk);
    chk(vec_addr_o === 32'h80, "R8 old base", vec_addr_o, 32'h80);
    idle();
    @(negedge clk);
    chk(vec_addr_o === 32'h4080, "R8/R10 new base", vec_addr_o, 32'h4080);

    // R4/R5 user-state attempt
    op(1'b1, 1'b0, 3'd2, 32'h1111_1111);
    idle();
    @(negedge clk);
    chk(priv_viol_o === 1'b1 && illegal_reg_o === 1'b0, "R5 pulse", 32'(priv_viol_o), 1);
    @(negedge clk);
    chk(priv_viol_o === 1'b0, "R5 one cycle", 32'(priv_viol_o), 0);
    rd(1'b1, 3'd2);
    chk(creg_rdata_o === 32'hDEAD_BEEF, "R4 usp unchanged", creg_rdata_o, 32'hDEAD_BEEF);
    rd(1'b0, 3'd3);
    chk(creg_rdata_o === 32'h0, "R4 user read zero", creg_rdata_o, 0);

    // R6 unknown select
    op(1'b1, 1'b1, 3'd5, 32'hFFFF_FFFF);
    idle();
    @(negedge clk);
    chk(illegal_reg_o === 1'b1, "R6 pulse", 32'(illegal_reg_o), 1);
    rd(1'b1, 3'd6);
    chk(creg_rdata_o === 32'h0 && illegal_reg_o === 1'b1, "R6 read zero", creg_rdata_o, 0);
    rd(1'b1, 3'd3);
    chk(creg_rdata_o === 32'h4000, "R6 vbr unchanged", creg_rdata_o, 32'h4000);

    // Random mix: collisions of writes with vector and alternate-space use
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #2;
      creg_req_i     = ($urandom_range(0, 2) != 0);
      creg_we_i      = $urandom_range(0, 1);
      supervisor_i   = ($urandom_range(0, 3) != 0);
      creg_sel_i     = ($urandom_range(0, 4) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
      creg_wdata_i   = $urandom;
      alt_is_write_i = $urandom_range(0, 1);
      exc_num_i      = 8'($urandom);
    end
    idle();
    @(negedge clk);
    chk_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule